// File: doc/BRIEF.md
# Deep-Colour Pixel-to-Lane Byte Packer

This block takes a raster of 30-bit RGB pixels and turns it into byte streams for eight display link lanes. The pixels come one per clock, each with 10 bits for red, green and blue. The lanes form two groups of four. The left half of each line feeds the first group and the right half feeds the second. Within a group, consecutive pixels are dealt round-robin across the four lanes.

Each lane treats its pixels as one continuous bitstream. The bits go red, then green, then blue, most significant bit first, with no padding between pixels. Bytes are cut from the front of that stream, so a byte may hold the tail of one pixel and the head of the next. Four pixels on one lane make exactly fifteen bytes.

A lane raises its byte strobe only in cycles where it has a whole byte to send. There is no backpressure toward the input. A line whose lanes do not end on a byte boundary is reported on an error pulse. A line counter tracks the vertical position within the frame.

Top module: `dpx_lane_packer`

## Requirements
- R1: Each pixel is the 30-bit word {red[9:0], green[9:0], blue[9:0]}. A lane's bytes are its pixels' bits concatenated in arrival order and cut MSB-first into 8-bit units, so a lane's first byte is red[9:2] of its first pixel and its fourth byte is blue[5:0] of that pixel followed by red[9:8] of the next.
- R2: Pixels at horizontal position 0 to LINE_W/2-1 go to lanes 0-3. Positions LINE_W/2 to LINE_W-1 go to lanes 4-7. Lane k's byte is `lane_byte[8k+7:8k]`.
- R3: Within a half-line, the pixel at offset n from the start of that half goes to lane n mod 4 of its group.
- R4: Four pixels on a lane produce exactly 15 bytes. A lane strobes at most one byte per cycle and strobes only when a complete byte is available. Whenever a whole byte is pending, the lane sends it in the next cycle.
- R5: If a pixel is sampled at clock edge K and completes a byte, that byte is on the registered lane outputs after edge K+1.
- R6: From the fourth cycle of a line until the first right-half pixel has been sampled, lanes 4-7 strobe nothing.
- R7: When a line starts (valid with start-of-line), `align_err` pulses for one cycle if any lane still holds a partial byte, that is, if any lane received a pixel count that is not a multiple of 4. Those partial bits are discarded and whole pending bytes are still sent. A full-width line causes no pulse.
- R8: Pixels at position LINE_W or beyond, and pixels before the first start-of-line after reset, produce no bytes.
- R9: `line_idx` is set to 0 by a start-of-line that also carries start-of-frame. A start-of-line without start-of-frame advances it, and it wraps from FRAME_H-1 to 0.
- R10: After reset all lane strobes and `align_err` are low and `line_idx` is 0.
- R11: Cycles with `pix_vld` low between pixels do not change any lane's byte sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_vld | input | 1 | Input pixel valid |
| pix_sol | input | 1 | First pixel of a line (qualified by pix_vld) |
| pix_sof | input | 1 | First line of a frame (qualified by pix_vld and pix_sol) |
| pix_rgb | input | 30 | Pixel {red, green, blue}, 10 bits each |
| lane_byte | output | 64 | Eight lane bytes, lane k in bits 8k+7:8k |
| lane_vld | output | 8 | Per-lane byte strobe |
| align_err | output | 1 | Partial byte discarded at a line start |
| line_idx | output | 12 | Current line number within the frame |

## Verification
The embedded properties watch each lane's pending bit count on every cycle. They check three things: a whole pending byte always leaves on the next cycle, no strobe appears without a byte to send, and the count never exceeds the accumulator's capacity. They also check that positions past the line width never feed a lane, and that the error pulse only ever follows a line start.

The actual byte contents and the routing across lanes and halves can only be shown by the bench's scenarios. So can the two-edge latency, the silence of the right-hand group, the error on a short line and the line-counter wrap. The bench compares every lane's complete byte sequence against one built independently from the pixel values.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
  localparam int COMP_W = 10;
  localparam int PIX_W  = 3 * COMP_W;
  localparam int BYTE_W = 8;
  typedef logic [PIX_W-1:0]  pix_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/dpx_pixel_router.sv
module dpx_pixel_router
  import dpx_pkg::*;
#(
  parameter int LINE_W    = 3840,
  parameter int FRAME_H   = 2160,
  parameter int GRP_LANES = 4,
  parameter int GROUPS    = 2,
  localparam int NL       = GRP_LANES * GROUPS,
  localparam int LW       = $clog2(FRAME_H)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic          in_sol,
  input  logic          in_sof,
  input  pix_t          in_pix,
  output pix_t          pix_q,
  output logic [NL-1:0] load_q,
  output logic          sol_q,
  output logic [LW-1:0] line_idx
);
  localparam int HALF = LINE_W / GROUPS;
  localparam int HW   = $clog2(LINE_W + 1);

  logic [HW-1:0] hpos;
  logic [HW-1:0] cur_pos;
  logic [HW-1:0] offset;
  logic          accept;
  int            grp_i;
  int            lane_i;
  int            idx_i;

  always_comb begin
    cur_pos = (in_vld && in_sol) ? '0 : hpos;
    accept  = in_vld && (cur_pos < HW'(LINE_W));
    grp_i   = 0;
    for (int g = 1; g < GROUPS; g++) begin
      if (cur_pos >= HW'(g * HALF)) grp_i = g;
    end
    offset  = cur_pos - HW'(grp_i * HALF);
    lane_i  = int'(offset) % GRP_LANES;
    idx_i   = grp_i * GRP_LANES + lane_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hpos     <= HW'(LINE_W);
      pix_q    <= '0;
      load_q   <= '0;
      sol_q    <= 1'b0;
      line_idx <= '0;
    end else begin
      pix_q  <= in_pix;
      sol_q  <= in_vld && in_sol;
      load_q <= accept ? (NL'(1) << idx_i) : '0;
      if (accept) hpos <= cur_pos + HW'(1);
      if (in_vld && in_sol) begin
        if (in_sof || (line_idx == LW'(FRAME_H - 1))) line_idx <= '0;
        else                                         line_idx <= line_idx + LW'(1);
      end
    end
  end

  // R8: once the line is exhausted, only a new line start can feed a lane
  a_r8_ignore_past_width: assert property (@(posedge clk) disable iff (rst)
    (hpos == HW'(LINE_W) && !(in_vld && in_sol)) |=> (load_q == '0));

endmodule

// File: rtl/dpx_lane_accum.sv
module dpx_lane_accum
  import dpx_pkg::*;
#(
  parameter int ACC_W = 38
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  logic  sol,
  input  pix_t  pix,
  output byte_t byte_q,
  output logic  vld_q,
  output logic  frac_err
);
  localparam int CW = $clog2(ACC_W + 1);
  localparam logic [ACC_W-1:0] ONES = '1;

  logic [ACC_W-1:0] acc;
  logic [CW-1:0]    cnt;
  logic [ACC_W-1:0] a_n;
  logic [CW-1:0]    c_n;
  logic             emit;
  byte_t            nb;

  always_comb begin
    a_n      = acc;
    c_n      = cnt;
    frac_err = 1'b0;
    emit     = 1'b0;
    nb       = '0;
    if (sol) begin
      if ((c_n % CW'(BYTE_W)) != '0) frac_err = 1'b1;
      c_n = c_n - (c_n % CW'(BYTE_W));
      a_n = a_n & ~(ONES >> c_n);
    end
    if (load) begin
      if (c_n > CW'(ACC_W - PIX_W)) begin
        frac_err = 1'b1;
        c_n      = '0;
        a_n      = '0;
      end
      a_n = a_n | ({pix, {(ACC_W - PIX_W){1'b0}}} >> c_n);
      c_n = c_n + CW'(PIX_W);
    end
    if (c_n >= CW'(BYTE_W)) begin
      emit = 1'b1;
      nb   = a_n[ACC_W-1 -: BYTE_W];
      a_n  = a_n << BYTE_W;
      c_n  = c_n - CW'(BYTE_W);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      cnt    <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      acc   <= a_n;
      cnt   <= c_n;
      vld_q <= emit;
      if (emit) byte_q <= nb;
    end
  end

  // R4: a whole pending byte leaves on the next cycle
  a_r4_drain: assert property (@(posedge clk) disable iff (rst)
    (cnt >= CW'(BYTE_W) && !sol) |=> vld_q);
  // R4: no strobe without a complete byte
  a_r4_no_empty_emit: assert property (@(posedge clk) disable iff (rst)
    (cnt < CW'(BYTE_W) && !load) |=> !vld_q);
  // R4: pending bits stay within capacity after each cycle's byte
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(ACC_W - BYTE_W));

endmodule

// File: rtl/dpx_lane_packer.sv
module dpx_lane_packer
  import dpx_pkg::*;
#(
  parameter int LINE_W    = 3840,
  parameter int FRAME_H   = 2160,
  parameter int GRP_LANES = 4,
  parameter int GROUPS    = 2,
  parameter int ACC_W     = 38,
  localparam int NL       = GRP_LANES * GROUPS,
  localparam int LW       = $clog2(FRAME_H)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pix_vld,
  input  logic                 pix_sol,
  input  logic                 pix_sof,
  input  logic [PIX_W-1:0]     pix_rgb,
  output logic [NL*BYTE_W-1:0] lane_byte,
  output logic [NL-1:0]        lane_vld,
  output logic                 align_err,
  output logic [LW-1:0]        line_idx
);
  pix_t          pix_q;
  logic [NL-1:0] load_q;
  logic          sol_q;
  logic [NL-1:0] frac;

  dpx_pixel_router #(
    .LINE_W(LINE_W), .FRAME_H(FRAME_H), .GRP_LANES(GRP_LANES), .GROUPS(GROUPS)
  ) u_router (
    .clk(clk), .rst(rst), .in_vld(pix_vld), .in_sol(pix_sol), .in_sof(pix_sof),
    .in_pix(pix_rgb), .pix_q(pix_q), .load_q(load_q), .sol_q(sol_q),
    .line_idx(line_idx)
  );

  for (genvar k = 0; k < NL; k++) begin : g_lane
    dpx_lane_accum #(.ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst(rst), .load(load_q[k]), .sol(sol_q), .pix(pix_q),
      .byte_q(lane_byte[k*BYTE_W +: BYTE_W]), .vld_q(lane_vld[k]),
      .frac_err(frac[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) align_err <= 1'b0;
    else     align_err <= |frac;
  end

  // R7: the alignment error only follows a line start
  a_r7_err_after_sol: assert property (@(posedge clk) disable iff (rst)
    align_err |-> $past(sol_q));

endmodule

// File: tb/tb_dpx_lane_packer.sv
module tb_dpx_lane_packer;
  localparam int LINE_W = 32;
  localparam int FRAME_H = 3;
  localparam int HALF = LINE_W / 2;
  localparam int NL = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_vld = 1'b0, pix_sol = 1'b0, pix_sof = 1'b0;
  logic [29:0] pix_rgb = '0;
  logic [NL*8-1:0] lane_byte;
  logic [NL-1:0] lane_vld;
  logic align_err;
  logic [1:0] line_idx;

  dpx_lane_packer #(.LINE_W(LINE_W), .FRAME_H(FRAME_H)) dut (
    .clk(clk), .rst(rst), .pix_vld(pix_vld), .pix_sol(pix_sol), .pix_sof(pix_sof),
    .pix_rgb(pix_rgb), .lane_byte(lane_byte), .lane_vld(lane_vld),
    .align_err(align_err), .line_idx(line_idx)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int sol_cyc = 0, rh_cyc = 0, first0_cyc = -1, b_early = 0, errs = 0;
  bit done = 0;
  logic [7:0] gotq [NL][$];
  logic [7:0] expq [NL][$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (!rst) begin
    for (int l = 0; l < NL; l++)
      if (lane_vld[l]) gotq[l].push_back(lane_byte[l*8 +: 8]);
    if (lane_vld[0] && first0_cyc < 0) first0_cyc = cyc;
    if (|lane_vld[7:4] && cyc >= sol_cyc + 4 && cyc <= rh_cyc) b_early++;
    if (align_err) errs++;
  end

  function automatic logic [29:0] pixval(int seed, int i);
    logic [9:0] r, g, b;
    r = 10'(seed * 37 + i * 13 + 5);
    g = 10'(seed * 11 + i * 29 + 300);
    b = 10'(seed * 5 + i * 71 + 700);
    return {r, g, b};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear();
    for (int l = 0; l < NL; l++) begin
      gotq[l].delete();
      expq[l].delete();
    end
    first0_cyc = -1; b_early = 0; errs = 0;
  endtask

  // expected per-lane bytes for a full-width line: R1 packing, R2 halves, R3 lanes
  task automatic build_exp(int seed);
    for (int g = 0; g < 2; g++)
      for (int l = 0; l < 4; l++)
        for (int k = 0; k < HALF; k += 16) begin
          logic [119:0] v;
          for (int m = 0; m < 4; m++)
            v[119 - 30*m -: 30] = pixval(seed, g*HALF + l + k + 4*m);
          for (int j = 0; j < 15; j++) expq[g*4 + l].push_back(v[119 - 8*j -: 8]);
        end
  endtask

  task automatic send_line(int seed, int n, int gap, bit sof);
    rh_cyc = 1 << 30;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_vld = 1'b1; pix_sol = (i == 0); pix_sof = sof && (i == 0);
      pix_rgb = pixval(seed, i);
      if (i == 0) sol_cyc = cyc + 1;
      if (i == HALF) rh_cyc = cyc + 1;
      for (int q = 0; q < gap; q++) begin
        @(negedge clk);
        pix_vld = 1'b0; pix_sol = 1'b0; pix_sof = 1'b0;
      end
    end
    @(negedge clk);
    pix_vld = 1'b0; pix_sol = 1'b0; pix_sof = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic compare(string tag);
    for (int l = 0; l < NL; l++) begin
      int bad = -1;
      chk(gotq[l].size() == expq[l].size(), {tag, " R4 byte count"}, gotq[l].size(), expq[l].size());
      for (int j = 0; j < gotq[l].size() && j < expq[l].size(); j++)
        if (bad < 0 && gotq[l][j] !== expq[l][j]) bad = j;
      if (bad >= 0) chk(0, {tag, " R1 R3 lane byte"}, gotq[l][bad], expq[l][bad]);
      else          chk(1, {tag, " R1 R3 lane byte"}, 0, 0);
    end
  endtask

  task automatic t_reset();
    chk(lane_vld == '0, "R10 strobes low", lane_vld, 0);
    chk(align_err == 1'b0, "R10 err low", align_err, 0);
    chk(line_idx == 2'd0, "R10 line idx", line_idx, 0);
  endtask

  task automatic t_before_sol();
    int tot;
    clear();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); pix_vld = 1'b1; pix_rgb = pixval(9, i);
    end
    @(negedge clk); pix_vld = 1'b0;
    idle(10);
    tot = 0;
    for (int l = 0; l < NL; l++) tot += gotq[l].size();
    chk(tot == 0, "R8 no bytes before first line start", tot, 0);
  endtask

  task automatic t_basic();
    clear(); build_exp(1);
    send_line(1, LINE_W, 0, 1'b1);
    idle(30);
    compare("basic");
    chk(errs == 0, "R7 no error on full line", errs, 0);
    chk(first0_cyc == sol_cyc + 1, "R5 latency", first0_cyc, sol_cyc + 1);
    chk(gotq[0].size() > 0 && gotq[0][0] == pixval(1, 0)[29:22], "R1 first byte red[9:2]",
        gotq[0].size() > 0 ? gotq[0][0] : -1, pixval(1, 0)[29:22]);
    chk(b_early == 0, "R6 right group quiet", b_early, 0);
    chk(line_idx == 2'd0, "R9 sof sets 0", line_idx, 0);
  endtask

  task automatic t_gaps();
    clear(); build_exp(2);
    send_line(2, LINE_W, 2, 1'b0);
    idle(30);
    compare("gaps R11");
    chk(b_early == 0, "R6 right group quiet with gaps", b_early, 0);
    chk(line_idx == 2'd1, "R9 advance", line_idx, 1);
  endtask

  task automatic t_overrun();
    clear(); build_exp(3);
    send_line(3, LINE_W + 6, 0, 1'b0);
    idle(30);
    compare("overrun R8");
    chk(line_idx == 2'd2, "R9 advance", line_idx, 2);
  endtask

  task automatic t_wrap();
    clear(); build_exp(4);
    send_line(4, LINE_W, 0, 1'b0);
    idle(30);
    chk(line_idx == 2'd0, "R9 wrap", line_idx, 0);
    send_line(4, LINE_W, 0, 1'b0);
    idle(30);
    send_line(4, LINE_W, 0, 1'b1);
    idle(30);
    chk(line_idx == 2'd0, "R9 sof restart", line_idx, 0);
  endtask

  task automatic t_short();
    send_line(5, 18, 0, 1'b0);
    idle(30);
    clear(); build_exp(6);
    send_line(6, LINE_W, 0, 1'b0);
    idle(30);
    chk(errs == 1, "R7 partial byte flagged", errs, 1);
    compare("after short R7");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_before_sol();
    t_basic();
    t_gaps();
    t_overrun();
    t_wrap();
    t_short();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule